// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel digital-to-analog converter. A three-wire serial port carries a chip select (active low), a serial clock and a data line. Each frame holds a two-bit channel address followed by a data code of `RES_BITS` bits. The frame is shifted in most significant bit first. When chip select returns high, the decoded address steers the data code into the input register of channel A, channel B, both, or neither.

A second rank of code registers sits behind the input registers and drives the two outputs. These are double buffered under an active-low load strobe. While the strobe is low the output registers follow the input registers. While it is high they hold, so two channels written one after the other can be changed together.

A system reset and a separate active-low clear input both force every input and output register to a preset value. The preset is zero or midscale, chosen by a mode pin. The serial clock, chip select, data line and load strobe are sampled into the system clock through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. The clear input and mode pin are taken as synchronous to the system clock.

The serial port is controlled by a three-state machine:
- `SP_IDLE` waits for chip select to go low, then moves to `SP_SHIFT`.
- `SP_SHIFT` takes one bit per serial clock rising edge. When chip select goes high it moves to `SP_COMMIT`.
- `SP_COMMIT` issues the one-cycle write strobe and returns to `SP_IDLE`.
- A clear, or a system reset, returns the machine to `SP_IDLE` from any state.

Top module: `sdac_front`

## Requirements
- R1: After system reset each output code equals the preset. The preset is 0 when `mid_sel` is 0 and 1 shifted left by `RES_BITS-1` when `mid_sel` is 1 (0x8000 at 16 bits).
- R2: A bit on `sdi` is taken on each rising edge of `sclk` only while `csn` is low. Clock edges while `csn` is high shift nothing. Bits arrive MSB first: address bit 1, address bit 0, then data bit `RES_BITS-1` down to data bit 0.
- R3: On the rising edge of `csn`, only the last `RES_BITS+2` bits shifted in are used. Earlier filler bits are discarded, so a 24-bit frame with six leading filler bits writes correctly.
- R4: Address 01 writes channel A only and address 10 writes channel B only. Address 00 leaves both input registers unchanged.
- R5: Address 11 writes the same data code into both channels.
- R6: While `ldn` is low, each output register follows its input register. With `ldn` held low, a completed frame appears at the outputs.
- R7: While `ldn` is high, the outputs hold their value. A low pulse on `ldn` then moves both input registers to the outputs together.
- R8: While `clr_n` is low, all input and output registers take the preset selected by `mid_sel` (see R1).
- R9: Clear has priority over serial writes and the load strobe. A frame that completes while `clr_n` is low writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset (power-on preset) |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| csn | input | 1 | Active-low chip select; rising edge commits the frame |
| sdi | input | 1 | Serial data, MSB first |
| ldn | input | 1 | Active-low level-sensitive load strobe for the output registers |
| clr_n | input | 1 | Active-low clear to preset |
| mid_sel | input | 1 | Preset select: 0 gives zero, 1 gives midscale |
| code_a | output | RES_BITS | Channel A output register code |
| code_b | output | RES_BITS | Channel B output register code |

## Verification
The hardest condition to reach from the ports is a chip-select edge that arrives while the block is being cleared. Reaching it needs the clear line held low across an entire serial frame and past its commit edge, then released.

A second hard case concerns clock pulses sent while chip select is high. Their absence from the shift register only shows if a later frame commits the register untouched. The stimulus does this by lowering and raising chip select with no clock pulses, which must rewrite the previous value.

Filler bits are driven as ones, so a faulty bit window would corrupt both the address and the data.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        SP_IDLE   = 2'd0,
        SP_SHIFT  = 2'd1,
        SP_COMMIT = 2'd2
    } sp_state_t;

    localparam int ADDR_BITS = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int          W         = 4,
    parameter logic [W-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= IDLE_VAL;
            stage2 <= IDLE_VAL;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/sdac_serial_fsm.sv
module sdac_serial_fsm
    import sdac_pkg::*;
#(
    parameter int RES_BITS = 16,
    localparam int WORD_W  = RES_BITS + ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_n,
    input  logic                 sclk_q,
    input  logic                 csn_q,
    input  logic                 sdi_q,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [RES_BITS-1:0]  wr_data
);
    sp_state_t   state;
    sp_state_t   state_nxt;
    logic        sclk_prev;
    logic        sclk_rise;
    logic [WORD_W-1:0] shreg;

    assign sclk_rise = sclk_q && !sclk_prev;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            state <= SP_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SP_IDLE:   if (!csn_q) state_nxt = SP_SHIFT;
            SP_SHIFT:  if (csn_q)  state_nxt = SP_COMMIT;
            SP_COMMIT: state_nxt = SP_IDLE;
            default:   state_nxt = SP_IDLE;
        endcase
    end

    // bit window: older bits fall off the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            shreg     <= '0;
        end else begin
            sclk_prev <= sclk_q;
            if (sclk_rise && !csn_q) begin
                shreg <= {shreg[WORD_W-2:0], sdi_q};
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = shreg[WORD_W-1 -: ADDR_BITS];
        wr_data = shreg[RES_BITS-1:0];
        unique case (state)
            SP_IDLE:   wr_en = 1'b0;
            SP_SHIFT:  wr_en = 1'b0;
            SP_COMMIT: wr_en = 1'b1;
            default:   wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdac_chan.sv
module sdac_chan #(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_n,
    input  logic [RES_BITS-1:0] preset,
    input  logic                wr_sel,
    input  logic [RES_BITS-1:0] wr_data,
    input  logic                ldn_q,
    output logic [RES_BITS-1:0] in_code,
    output logic [RES_BITS-1:0] out_code
);
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            in_code  <= preset;
            out_code <= preset;
        end else begin
            if (wr_sel) begin
                in_code <= wr_data;
            end
            if (!ldn_q) begin
                out_code <= in_code;
            end
        end
    end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                csn,
    input  logic                sdi,
    input  logic                ldn,
    input  logic                clr_n,
    input  logic                mid_sel,
    output logic [RES_BITS-1:0] code_a,
    output logic [RES_BITS-1:0] code_b
);
    localparam int NCH = 2;
    localparam logic [RES_BITS-1:0] MID_CODE = RES_BITS'(1) << (RES_BITS - 1);

    logic [3:0]                sync_q;
    logic                      sclk_q;
    logic                      csn_q;
    logic                      sdi_q;
    logic                      ldn_q;
    logic                      wr_en;
    logic [ADDR_BITS-1:0]      wr_addr;
    logic [RES_BITS-1:0]       wr_data;
    logic [RES_BITS-1:0]       preset;
    logic [RES_BITS-1:0]       in_codes  [NCH];
    logic [RES_BITS-1:0]       out_codes [NCH];

    assign preset = mid_sel ? MID_CODE : '0;

    sdac_sync #(.W(4), .IDLE_VAL(4'b1100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ldn, csn, sclk, sdi}),
        .sync_out (sync_q)
    );
    assign {ldn_q, csn_q, sclk_q, sdi_q} = sync_q;

    sdac_serial_fsm #(.RES_BITS(RES_BITS)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .sclk_q  (sclk_q),
        .csn_q   (csn_q),
        .sdi_q   (sdi_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // address bit k selects channel k (bit 0 -> A, bit 1 -> B)
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sdac_chan #(.RES_BITS(RES_BITS)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_n    (clr_n),
            .preset   (preset),
            .wr_sel   (wr_en && wr_addr[ch]),
            .wr_data  (wr_data),
            .ldn_q    (ldn_q),
            .in_code  (in_codes[ch]),
            .out_code (out_codes[ch])
        );
    end

    assign code_a = out_codes[0];
    assign code_b = out_codes[1];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int RES_BITS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_n,
    input logic                mid_sel,
    input logic                ldn_q,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [RES_BITS-1:0] in_a,
    input logic [RES_BITS-1:0] in_b,
    input logic [RES_BITS-1:0] code_a,
    input logic [RES_BITS-1:0] code_b
);
    localparam logic [RES_BITS-1:0] MID_CODE = RES_BITS'(1) << (RES_BITS - 1);

    AST_CLEAR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (code_a == ($past(mid_sel) ? MID_CODE : '0)) &&
                   (code_b == ($past(mid_sel) ? MID_CODE : '0))); // R8

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && wr_en) |=> (in_a == ($past(mid_sel) ? MID_CODE : '0))); // R9

    AST_NO_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && wr_en && wr_addr == 2'b00) |=> $stable(in_a) && $stable(in_b)); // R4

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ldn_q) |=> $stable(code_a) && $stable(code_b)); // R7

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ldn_q) |=> (code_a == $past(in_a)) && (code_b == $past(in_b))); // R6

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
endmodule

bind sdac_front sdac_front_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .mid_sel (mid_sel),
    .ldn_q   (ldn_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .in_a    (in_codes[0]),
    .in_b    (in_codes[1]),
    .code_a  (code_a),
    .code_b  (code_b)
);

// File: tb/sdac_front_test.sv
module sdac_front_test;
    localparam int N = 16;
    localparam logic [N-1:0] MID = 16'h8000;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         csn = 1'b1;
    logic         sdi = 1'b0;
    logic         ldn = 1'b0;
    logic         clr_n = 1'b1;
    logic         mid_sel = 1'b0;
    logic [N-1:0] code_a;
    logic [N-1:0] code_b;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];
    event sample_req;
    event sample_done;
    bit   finished = 1'b0;

    // bench model of the registers
    logic [N-1:0] m_in_a, m_in_b, m_out_a, m_out_b;

    always #5 clk = ~clk;

    sdac_front #(.RES_BITS(N)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
        .ldn(ldn), .clr_n(clr_n), .mid_sel(mid_sel),
        .code_a(code_a), .code_b(code_b)
    );

    // monitor: pops the expected pair and compares it
    initial begin
        forever begin
            @(sample_req);
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (code_a !== e.a || code_b !== e.b) begin
                    failures++;
                    $display("FAIL %s: code_a=%h code_b=%h expected a=%h b=%h",
                             e.tag, code_a, code_b, e.a, e.b);
                end
            end
            ->sample_done;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_now(input string tag);
        exp_t e;
        wait_clk(8);
        e.a = m_out_a;
        e.b = m_out_b;
        e.tag = tag;
        exp_q.push_back(e);
        ->sample_req;
        @(sample_done);
    endtask

    task automatic model_preset();
        logic [N-1:0] p;
        p = mid_sel ? MID : '0;
        m_in_a = p; m_in_b = p; m_out_a = p; m_out_b = p;
    endtask

    task automatic clock_bits(input int nbits, input logic [31:0] word);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = word[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
    endtask

    // send a frame; the model is updated only when apply is set
    task automatic frame(input int nbits, input logic [31:0] word, input bit apply);
        logic [1:0]   ad;
        logic [N-1:0] dt;
        csn = 1'b0;
        wait_clk(4);
        clock_bits(nbits, word);
        wait_clk(4);
        csn = 1'b1;
        ad = word[N+1:N];
        dt = word[N-1:0];
        if (apply) begin
            if (ad[0]) m_in_a = dt;
            if (ad[1]) m_in_b = dt;
            if (!ldn) begin m_out_a = m_in_a; m_out_b = m_in_b; end
        end
    endtask

    initial begin
        // R1: power-on preset with mode 0
        mid_sel = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        model_preset();
        expect_now("R1 zero preset at reset");

        // R1: power-on preset with mode 1
        rst_n = 1'b0;
        mid_sel = 1'b1;
        wait_clk(4);
        rst_n = 1'b1;
        model_preset();
        expect_now("R1 midscale preset at reset");

        // R6: load strobe low, write A then B
        frame(18, {2'b01, 16'h1234}, 1'b1);
        expect_now("R6 R4 write channel A");
        frame(18, {2'b10, 16'hBEEF}, 1'b1);
        expect_now("R4 write channel B");

        // R5: broadcast
        frame(18, {2'b11, 16'h5A5A}, 1'b1);
        expect_now("R5 broadcast");

        // R4: no address selected
        frame(18, {2'b00, 16'hFFFF}, 1'b1);
        expect_now("R4 address 00 no change");

        // R3: 24-bit frame with six filler ones
        frame(24, {8'h00, 6'b111111, 2'b01, 16'h0F0F}, 1'b1);
        expect_now("R3 filler bits discarded");

        // R2: clocks with csn high shift nothing
        frame(18, {2'b10, 16'h2222}, 1'b1);
        sdi = 1'b1;
        for (int k = 0; k < 20; k++) begin
            wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        end
        csn = 1'b0;
        wait_clk(8);
        csn = 1'b1;
        expect_now("R2 clocks ignored with csn high");
        frame(20, {12'h000, 2'b01, 2'b00, 16'h0000}, 1'b1);
        expect_now("R2 MSB-first address then data");

        // R7: double buffer
        ldn = 1'b1;
        wait_clk(4);
        frame(18, {2'b01, 16'hAAAA}, 1'b1);
        expect_now("R7 hold after write A");
        frame(18, {2'b10, 16'h5555}, 1'b1);
        expect_now("R7 hold after write B");
        ldn = 1'b0;
        wait_clk(4);
        ldn = 1'b1;
        m_out_a = m_in_a; m_out_b = m_in_b;
        expect_now("R7 simultaneous update on load pulse");
        ldn = 1'b0;

        // R8: clear to midscale and to zero
        clr_n = 1'b0;
        mid_sel = 1'b1;
        wait_clk(2);
        clr_n = 1'b1;
        model_preset();
        expect_now("R8 clear to midscale");
        frame(18, {2'b11, 16'h7777}, 1'b1);
        expect_now("R5 broadcast before clear");
        mid_sel = 1'b0;
        clr_n = 1'b0;
        wait_clk(2);
        clr_n = 1'b1;
        model_preset();
        expect_now("R8 clear to zero");

        // R9: frame completing during clear writes nothing
        clr_n = 1'b0;
        frame(18, {2'b11, 16'h1357}, 1'b0);
        wait_clk(10);
        clr_n = 1'b1;
        model_preset();
        expect_now("R9 clear beats write");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule